// File: doc/BRIEF.md
# Two-Cycle Command/Address Decoder

This block sits on the receiving end of a narrow 14-bit command/address bus. It accepts commands that occupy one or two bus beats. A beat is taken when the select strobe `ca_sel` is high on a rising clock edge. The opcode bits of the first beat decide whether a second beat follows. When a two-beat command finishes, the block joins both beats into a 28-bit payload. It then presents the decoded command kind together with bank group, bank, row, column and chip-ID fields. A one-cycle `cmd_valid` pulse qualifies these outputs.

The decoder handles five commands. Precharge uses one beat. Activate, read, write and write-pattern use two beats. A spare payload bit can extend either the chip ID or the row address; the `cfg_ext_row` input chooses which. Columns arrive without their three lowest bits, so the decoded column always has those bits at zero. Two error cases are reported instead of a command: a beat whose opcode is unknown, and a second select that arrives while the second beat of a command is still expected.

Top module: `cad_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release, `cmd_valid`, `cmd_illegal` and `frame_err` are 0 and no command is pending.
- R2: Precharge is a single beat with `ca_bus[3:0]=4'b0001`, bank group in `[6:4]`, bank in `[8:7]`, chip ID in `[11:9]` and the spare bit in `[12]`. `cmd_valid` rises in the cycle after the beat, with `cmd_kind=0`, and `cmd_row` and `cmd_col` equal to 0.
- R3: Activate is marked by `ca_bus[1:0]=2'b00` on the first beat. That beat carries bank group `[4:2]`, bank `[6:5]`, chip ID `[9:7]`, the spare bit `[10]` and row bits 2..0 in `[13:11]`. The second beat carries row bits 16..3 in `[13:0]`. `cmd_kind` is 1, and `cmd_valid` stays low after the first beat and rises in the cycle after the second beat.
- R4: Read, write and write-pattern use first-beat opcodes `4'b0101`, `4'b1001` and `4'b1101`, with the same field layout as precharge. Their second beat carries column bits 10..3 in `ca_bus[7:0]`. `cmd_col` equals those bits shifted left by three with bits 2..0 at zero. `cmd_kind` is 2, 3 or 4 respectively.
- R5: When `cfg_ext_row`=1 at the final beat, the spare bit becomes `cmd_row[17]` and `cmd_cid[3]`=0. When it is 0, the spare bit becomes `cmd_cid[3]` and `cmd_row[17]`=0.
- R6: A select during the expected second beat drops the partial command and pulses `frame_err` for one cycle without `cmd_valid`. The colliding beat is discarded and does not start a new command.
- R7: A first beat whose opcode is none of the above pulses `cmd_illegal` for one cycle, with `cmd_valid` low, and no second beat is expected.
- R8: A cycle with `ca_sel` low and no pending command produces no `cmd_valid`, `cmd_illegal` or `frame_err` in the next cycle.
- R9: `cmd_valid` lasts exactly one cycle per command. Back-to-back one-beat commands produce pulses in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ext_row | input | 1 | 1: spare bit extends the row; 0: spare bit extends the chip ID |
| ca_sel | input | 1 | Beat strobe, active high |
| ca_bus | input | 14 | Command/address beat |
| cmd_valid | output | 1 | One-cycle pulse: decoded command present |
| cmd_kind | output | 3 | 0 precharge, 1 activate, 2 read, 3 write, 4 write-pattern |
| cmd_bg | output | 3 | Bank group |
| cmd_ba | output | 2 | Bank |
| cmd_row | output | 18 | Row address, bit 17 from the spare bit in row mode |
| cmd_col | output | 11 | Column address, bits 2..0 zero |
| cmd_cid | output | 4 | Chip ID, bit 3 from the spare bit in chip-ID mode |
| cmd_illegal | output | 1 | One-cycle pulse: unknown opcode |
| frame_err | output | 1 | One-cycle pulse: second beat collided with a select |

## Verification
The assertions assume that `ca_bus` and `cfg_ext_row` are stable around each rising edge. They also assume that `cfg_ext_row` does not change in the edge before a command completes. The row-mode check compares against the value of that input one cycle earlier. The bench changes inputs only on falling edges and sets the configuration before it sends a command. It never toggles the configuration in the middle of a command.

// File: rtl/cad_pkg.sv
package cad_pkg;
    parameter int CA_W    = 14;
    parameter int BG_W    = 3;
    parameter int BA_W    = 2;
    parameter int ROW_W   = 17;
    parameter int CID_W   = 3;
    parameter int COL_HI  = 8;
    parameter int COL_LSB = 3;
    localparam int ROW_LO_W = CA_W * 2 - 2 - BG_W - BA_W - CID_W - 1 - CA_W;
    localparam int ROW_OUT_W = ROW_W + 1;
    localparam int CID_OUT_W = CID_W + 1;
    localparam int COL_W     = COL_HI + COL_LSB;

    typedef enum logic [2:0] {
        K_PRE = 3'd0,
        K_ACT = 3'd1,
        K_RD  = 3'd2,
        K_WR  = 3'd3,
        K_WRP = 3'd4
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e               kind;
        logic [BG_W-1:0]         bg;
        logic [BA_W-1:0]         ba;
        logic [CID_W-1:0]        cid;
        logic                    ext;
        logic [ROW_LO_W-1:0]     row_lo;
    } first_beat_t;
endpackage

// File: rtl/cad_first_decode.sv
module cad_first_decode
    import cad_pkg::*;
(
    input  logic [CA_W-1:0] ca,
    output first_beat_t     beat,
    output logic            two_beat,
    output logic            bad_op
);
    always_comb begin
        beat     = '0;
        two_beat = 1'b0;
        bad_op   = 1'b0;
        if (ca[1:0] == 2'b00) begin
            beat.kind   = K_ACT;
            beat.bg     = ca[4:2];
            beat.ba     = ca[6:5];
            beat.cid    = ca[9:7];
            beat.ext    = ca[10];
            beat.row_lo = ca[13:11];
            two_beat    = 1'b1;
        end else begin
            beat.bg  = ca[6:4];
            beat.ba  = ca[8:7];
            beat.cid = ca[11:9];
            beat.ext = ca[12];
            case (ca[3:0])
                4'b0001: beat.kind = K_PRE;
                4'b0101: begin beat.kind = K_RD;  two_beat = 1'b1; end
                4'b1001: begin beat.kind = K_WR;  two_beat = 1'b1; end
                4'b1101: begin beat.kind = K_WRP; two_beat = 1'b1; end
                default: bad_op = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cad_field_map.sv
module cad_field_map
    import cad_pkg::*;
(
    input  logic                 ext_row_mode,
    input  first_beat_t          first,
    input  logic [CA_W-1:0]      second,
    output logic [ROW_OUT_W-1:0] row,
    output logic [COL_W-1:0]     col,
    output logic [CID_OUT_W-1:0] cid
);
    always_comb begin
        row = '0;
        col = '0;
        cid = {(ext_row_mode ? 1'b0 : first.ext), first.cid};
        if (first.kind == K_ACT) begin
            row = {(ext_row_mode ? first.ext : 1'b0), second, first.row_lo};
        end else if (first.kind != K_PRE) begin
            row[ROW_W] = ext_row_mode ? first.ext : 1'b0;
            col = {second[COL_HI-1:0], {COL_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/cad_decoder.sv
module cad_decoder
    import cad_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_ext_row,
    input  logic                 ca_sel,
    input  logic [CA_W-1:0]      ca_bus,
    output logic                 cmd_valid,
    output logic [2:0]           cmd_kind,
    output logic [BG_W-1:0]      cmd_bg,
    output logic [BA_W-1:0]      cmd_ba,
    output logic [ROW_OUT_W-1:0] cmd_row,
    output logic [COL_W-1:0]     cmd_col,
    output logic [CID_OUT_W-1:0] cmd_cid,
    output logic                 cmd_illegal,
    output logic                 frame_err
);
    typedef struct packed {
        logic                 waiting;
        first_beat_t          held;
        logic                 valid;
        cmd_kind_e            kind;
        logic [BG_W-1:0]      bg;
        logic [BA_W-1:0]      ba;
        logic [ROW_OUT_W-1:0] row;
        logic [COL_W-1:0]     col;
        logic [CID_OUT_W-1:0] cid;
        logic                 illegal;
        logic                 ferr;
    } state_t;

    state_t st_d, st_q;

    first_beat_t          dec_beat;
    logic                 dec_two;
    logic                 dec_bad;
    first_beat_t          map_first;
    logic [CA_W-1:0]      map_second;
    logic [ROW_OUT_W-1:0] map_row;
    logic [COL_W-1:0]     map_col;
    logic [CID_OUT_W-1:0] map_cid;

    cad_first_decode i_first (
        .ca       (ca_bus),
        .beat     (dec_beat),
        .two_beat (dec_two),
        .bad_op   (dec_bad)
    );

    assign map_first  = st_q.waiting ? st_q.held : dec_beat;
    assign map_second = st_q.waiting ? ca_bus : '0;

    cad_field_map i_map (
        .ext_row_mode (cfg_ext_row),
        .first        (map_first),
        .second       (map_second),
        .row          (map_row),
        .col          (map_col),
        .cid          (map_cid)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.illegal = 1'b0;
        st_d.ferr    = 1'b0;
        if (st_q.waiting) begin
            st_d.waiting = 1'b0;
            if (ca_sel) begin
                st_d.ferr = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.kind  = map_first.kind;
                st_d.bg    = map_first.bg;
                st_d.ba    = map_first.ba;
                st_d.row   = map_row;
                st_d.col   = map_col;
                st_d.cid   = map_cid;
            end
        end else if (ca_sel) begin
            if (dec_bad) begin
                st_d.illegal = 1'b1;
            end else if (dec_two) begin
                st_d.waiting = 1'b1;
                st_d.held    = dec_beat;
            end else begin
                st_d.valid = 1'b1;
                st_d.kind  = map_first.kind;
                st_d.bg    = map_first.bg;
                st_d.ba    = map_first.ba;
                st_d.row   = map_row;
                st_d.col   = map_col;
                st_d.cid   = map_cid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid   = st_q.valid;
    assign cmd_kind    = st_q.kind;
    assign cmd_bg      = st_q.bg;
    assign cmd_ba      = st_q.ba;
    assign cmd_row     = st_q.row;
    assign cmd_col     = st_q.col;
    assign cmd_cid     = st_q.cid;
    assign cmd_illegal = st_q.illegal;
    assign frame_err   = st_q.ferr;

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, cmd_illegal, frame_err})); // R7
    AST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_col[COL_LSB-1:0] == '0); // R4
    AST_SECOND_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.waiting && !ca_sel) |=> cmd_valid); // R3
    AST_COLLISION_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.waiting && ca_sel) |=> (frame_err && !cmd_valid && !st_q.waiting)); // R6
    AST_ROW_MODE_CID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(cfg_ext_row)) |-> !cmd_cid[CID_W]); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.waiting && !ca_sel) |=> !(cmd_valid || cmd_illegal || frame_err)); // R8
endmodule

// File: tb/test_cad_decoder.sv
module test_cad_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ext_row = 1'b0;
    logic        ca_sel = 1'b0;
    logic [13:0] ca_bus = '0;
    logic        cmd_valid, cmd_illegal, frame_err;
    logic [2:0]  cmd_kind, cmd_bg;
    logic [1:0]  cmd_ba;
    logic [17:0] cmd_row;
    logic [10:0] cmd_col;
    logic [3:0]  cmd_cid;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cad_decoder i_cad_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_ext_row(cfg_ext_row), .ca_sel(ca_sel),
        .ca_bus(ca_bus), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_cid(cmd_cid), .cmd_illegal(cmd_illegal), .frame_err(frame_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic sel, input logic [13:0] v);
        @(negedge clk);
        ca_sel = sel;
        ca_bus = v;
        @(posedge clk);
        #1;
        ca_sel = 1'b0;
    endtask

    function automatic logic [13:0] act1(input logic [2:0] bg, input logic [1:0] ba,
                                         input logic [2:0] cid, input logic ext, input logic [16:0] row);
        return {row[2:0], ext, cid, ba, bg, 2'b00};
    endfunction

    function automatic logic [13:0] op1(input logic [3:0] op, input logic [2:0] bg, input logic [1:0] ba,
                                        input logic [2:0] cid, input logic ext);
        return {1'b0, ext, cid, ba, bg, op};
    endfunction

    task automatic t_reset;
        #5;
        chk("R1 valid in reset", cmd_valid, 0);
        chk("R1 illegal in reset", cmd_illegal, 0);
        chk("R1 ferr in reset", frame_err, 0);
        @(negedge clk); rst_n = 1'b1;
        beat(1'b0, 14'h3FFF);
        chk("R8 idle valid", cmd_valid, 0);
        chk("R8 idle flags", {cmd_illegal, frame_err}, 0);
    endtask

    task automatic t_pre;
        cfg_ext_row = 1'b0;
        beat(1'b1, op1(4'b0001, 3'd5, 2'd2, 3'd6, 1'b1));
        chk("R2 valid", cmd_valid, 1);
        chk("R2 kind", cmd_kind, 0);
        chk("R2 bg", cmd_bg, 5);
        chk("R2 ba", cmd_ba, 2);
        chk("R5 cid ext", cmd_cid, 4'hE);
        chk("R2 row", cmd_row, 0);
        chk("R2 col", cmd_col, 0);
        beat(1'b0, '0);
        chk("R9 pulse ends", cmd_valid, 0);
        beat(1'b1, op1(4'b0001, 3'd1, 2'd1, 3'd1, 1'b0));
        chk("R9 b2b first", cmd_valid, 1);
        beat(1'b1, op1(4'b0001, 3'd7, 2'd3, 3'd2, 1'b0));
        chk("R9 b2b second", cmd_valid, 1);
        chk("R9 b2b bg", cmd_bg, 7);
        beat(1'b0, '0);
    endtask

    task automatic t_act;
        logic [16:0] r = 17'h1A5C3;
        cfg_ext_row = 1'b1;
        beat(1'b1, act1(3'd3, 2'd1, 3'd5, 1'b1, r));
        chk("R3 no valid after beat1", cmd_valid, 0);
        beat(1'b0, r[16:3]);
        chk("R3 valid", cmd_valid, 1);
        chk("R3 kind", cmd_kind, 1);
        chk("R3 bg", cmd_bg, 3);
        chk("R3 ba", cmd_ba, 1);
        chk("R5 row ext", cmd_row, {1'b1, r});
        chk("R5 cid3 zero", cmd_cid, 4'h5);
        beat(1'b0, '0);
        chk("R9 act pulse ends", cmd_valid, 0);
        cfg_ext_row = 1'b0;
        beat(1'b1, act1(3'd6, 2'd3, 3'd0, 1'b1, 17'h0FFFF));
        beat(1'b0, 14'h1FFF);
        chk("R5 row17 zero", cmd_row, {1'b0, 17'h0FFFF});
        chk("R5 cid3 set", cmd_cid, 4'h8);
    endtask

    task automatic t_col(input logic [3:0] op, input logic [2:0] kind, input logic [7:0] c);
        cfg_ext_row = 1'b1;
        beat(1'b1, op1(op, 3'd2, 2'd3, 3'd4, 1'b1));
        chk("R4 no valid after beat1", cmd_valid, 0);
        beat(1'b0, {6'h3F, c});
        chk("R4 valid", cmd_valid, 1);
        chk("R4 kind", cmd_kind, kind);
        chk("R4 col", cmd_col, {c, 3'b000});
        chk("R4 bg/ba", {cmd_bg, cmd_ba}, {3'd2, 2'd3});
        chk("R5 rd row17", cmd_row, 18'h20000);
        chk("R5 rd cid", cmd_cid, 4'h4);
    endtask

    task automatic t_illegal;
        beat(1'b1, op1(4'b0011, 3'd1, 2'd1, 3'd1, 1'b0));
        chk("R7 illegal", cmd_illegal, 1);
        chk("R7 no valid", cmd_valid, 0);
        beat(1'b0, '0);
        chk("R7 no second beat", {cmd_valid, cmd_illegal, frame_err}, 0);
    endtask

    task automatic t_frame;
        cfg_ext_row = 1'b0;
        beat(1'b1, op1(4'b0101, 3'd1, 2'd0, 3'd0, 1'b0));
        beat(1'b1, op1(4'b0001, 3'd4, 2'd1, 3'd3, 1'b0));
        chk("R6 ferr", frame_err, 1);
        chk("R6 no valid", cmd_valid, 0);
        beat(1'b0, 14'h00AA);
        chk("R6 colliding beat dropped", {cmd_valid, cmd_illegal, frame_err}, 0);
        beat(1'b1, op1(4'b1001, 3'd0, 2'd2, 3'd7, 1'b0));
        beat(1'b0, 14'h0011);
        chk("R6 recovers", {cmd_valid, cmd_kind}, {1'b1, 3'd3});
        chk("R6 recover col", cmd_col, 11'h088);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_pre();
        t_act();
        t_col(4'b0101, 3'd2, 8'hB7);
        t_col(4'b1001, 3'd3, 8'h01);
        t_col(4'b1101, 3'd4, 8'hFF);
        t_illegal();
        t_frame();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule